// File: doc/BRIEF.md
# Reset Cause Flag Register

This block keeps the four flags that let firmware of a small processor core work out why it last came out of reset or sleep: a power-on flag, a brown-out flag, a time-out flag and a power-down flag. Each reset or wake event arrives as a one-cycle strobe. The event is ranked against any others in the same cycle. The winning event then sets, clears or keeps each flag according to its own fixed pattern. Because each cause leaves a different combination, firmware can identify the most recent cause from the flags alone.

Firmware sets the power-on and brown-out flags to 1 after it has read them. A later 0 in either flag then marks a fresh power-on or brown-out. Two further enable bits share the control byte with those flags and are plain read/write storage. The sleep and watchdog-clear instructions also reach the block as strobes, and they move the time-out and power-down flags. A 2-bit brown-out configuration input switches the brown-out detector off when it is 00.

Top module: `reset_cause_flags`

## Requirements
- R1: A power-on strobe, or the synchronous reset `rst`, gives power-on flag 0, time-out 1, power-down 1 and both enable bits 0. The brown-out flag is undefined after power-on (the design holds 0).
- R2: A brown-out strobe with `bor_cfg` not 00 gives brown-out flag 0, time-out 1, power-down 1 and both enable bits 0. The power-on flag keeps its value.
- R3: A brown-out strobe while `bor_cfg` is 00 has no effect on any output.
- R4: A watchdog reset strobe with `asleep` low clears time-out. The power-on, brown-out and power-down flags and the enables keep their values.
- R5: A watchdog wake strobe, or a watchdog reset strobe with `asleep` high, clears both time-out and power-down. The power-on and brown-out flags keep their values.
- R6: A pin reset strobe with `asleep` low leaves every flag and enable unchanged.
- R7: A pin-reset-in-sleep strobe, or a pin reset strobe with `asleep` high, gives time-out 1 and power-down 0. The other flags keep their values.
- R8: When no reset event is present, the sleep-instruction strobe gives time-out 1 and power-down 0, and the watchdog-clear strobe gives time-out 1 and power-down 1. If both strobes arrive together, the sleep strobe wins.
- R9: When `wr_en` is high and no reset event is present, the write data is applied as follows. A 1 in bit 1 sets the power-on flag and a 1 in bit 0 sets the brown-out flag; a 0 in either bit has no effect. Bits 7 and 6 load the two enable bits. Bits 5 to 2 are ignored.
- R10: Event priority is power-on, then brown-out, then watchdog (wake above reset), then pin reset. Any reset event overrides a same-cycle write or instruction strobe.
- R11: `ctrl_o` holds the enables in bits 7 and 6, 0 in bits 5 to 2, the power-on flag in bit 1 and the brown-out flag in bit 0. `stat_o` holds time-out in bit 3, power-down in bit 2, power-on in bit 1 and brown-out in bit 0.
- R12: All outputs are registered. An event sampled at a rising clock edge is visible right after that edge.
- R13: The power-on flag falls only on power-on. The brown-out flag falls only on power-on or on brown-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, same effect as power-on |
| ev_pwr_on | input | 1 | Power-on event strobe |
| ev_brown | input | 1 | Brown-out event strobe |
| ev_wdt_rst | input | 1 | Watchdog reset strobe |
| ev_wdt_wake | input | 1 | Watchdog wake-from-sleep strobe |
| ev_pin_rst | input | 1 | External pin reset strobe |
| ev_pin_sleep | input | 1 | External pin reset during sleep strobe |
| ev_sleep_op | input | 1 | Sleep instruction executed |
| ev_wdt_clr | input | 1 | Watchdog clear instruction executed |
| asleep | input | 1 | Core is currently in sleep |
| bor_cfg | input | 2 | Brown-out detector configuration, 00 = off |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write data |
| ctrl_o | output | 8 | Control byte: enables, power-on and brown-out flags |
| stat_o | output | 4 | Status nibble: time-out, power-down, power-on, brown-out |

## Verification
The bench builds the block with its default parameters: an 8-bit control byte and a 2-bit brown-out configuration. With these values every configuration code, including the disabled code 00, and every bit of the write byte can be reached by random stimulus. Random cycles often fire several strobes together, with random `asleep` values, so the priority ladder and the sleep-dependent variants of the watchdog and pin events are exercised many times. The brown-out flag is treated as don't-care from power-on until it is either written to 1 or cleared by a brown-out.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    localparam int POR_POS = 1;
    localparam int BOR_POS = 0;
    localparam int STAT_W  = 4;

    typedef enum logic [2:0] {
        K_NONE,
        K_POR,
        K_BOR,
        K_WDT_WAKE,
        K_WDT_RST,
        K_PIN_SLEEP,
        K_PIN_RST
    } rst_kind_e;

    typedef enum logic [1:0] {
        I_NONE,
        I_SLEEP,
        I_CLR
    } instr_e;

    typedef struct packed {
        logic por;
        logic bor;
        logic to;
        logic pd;
    } flags_t;

    localparam flags_t FLAGS_PWR_ON = '{por: 1'b0, bor: 1'b0, to: 1'b1, pd: 1'b1};

    function automatic flags_t apply_reset(input rst_kind_e k, input flags_t f);
        flags_t n;
        n = f;
        case (k)
            K_POR:       n = FLAGS_PWR_ON;
            K_BOR:       begin n.bor = 1'b0; n.to = 1'b1; n.pd = 1'b1; end
            K_WDT_WAKE:  begin n.to = 1'b0; n.pd = 1'b0; end
            K_WDT_RST:   n.to = 1'b0;
            K_PIN_SLEEP: begin n.to = 1'b1; n.pd = 1'b0; end
            default:     n = f;
        endcase
        return n;
    endfunction

    function automatic logic kind_clears_en(input rst_kind_e k);
        return (k == K_POR) || (k == K_BOR);
    endfunction

endpackage

// File: rtl/rcf_arbiter.sv
module rcf_arbiter
    import rcf_pkg::*;
#(
    parameter int BORCFG_W = 2
) (
    input  logic                ev_pwr_on,
    input  logic                ev_brown,
    input  logic                ev_wdt_rst,
    input  logic                ev_wdt_wake,
    input  logic                ev_pin_rst,
    input  logic                ev_pin_sleep,
    input  logic                ev_sleep_op,
    input  logic                ev_wdt_clr,
    input  logic                asleep,
    input  logic [BORCFG_W-1:0] bor_cfg,
    output rst_kind_e           kind,
    output instr_e              instr
);

    logic bor_on;
    assign bor_on = |bor_cfg;

    always_comb begin
        if (ev_pwr_on)
            kind = K_POR;
        else if (ev_brown && bor_on)
            kind = K_BOR;
        else if (ev_wdt_wake || (ev_wdt_rst && asleep))
            kind = K_WDT_WAKE;
        else if (ev_wdt_rst)
            kind = K_WDT_RST;
        else if (ev_pin_sleep || (ev_pin_rst && asleep))
            kind = K_PIN_SLEEP;
        else if (ev_pin_rst)
            kind = K_PIN_RST;
        else
            kind = K_NONE;
    end

    always_comb begin
        if (kind != K_NONE)
            instr = I_NONE;
        else if (ev_sleep_op)
            instr = I_SLEEP;
        else if (ev_wdt_clr)
            instr = I_CLR;
        else
            instr = I_NONE;
    end

endmodule

// File: rtl/rcf_flag_reg.sv
module rcf_flag_reg
    import rcf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rst_kind_e kind,
    input  instr_e    instr,
    input  logic      wr_en,
    input  logic      wr_por,
    input  logic      wr_bor,
    input  logic [1:0] wr_en_bits,
    output flags_t    flags,
    output logic [1:0] en_bits
);

    flags_t     f_nxt;
    logic [1:0] e_nxt;

    always_comb begin
        f_nxt = flags;
        e_nxt = en_bits;
        if (kind != K_NONE) begin
            f_nxt = apply_reset(kind, flags);
            if (kind_clears_en(kind))
                e_nxt = 2'b00;
        end else begin
            if (wr_en) begin
                if (wr_por) f_nxt.por = 1'b1;
                if (wr_bor) f_nxt.bor = 1'b1;
                e_nxt = wr_en_bits;
            end
            case (instr)
                I_SLEEP: begin f_nxt.to = 1'b1; f_nxt.pd = 1'b0; end
                I_CLR:   begin f_nxt.to = 1'b1; f_nxt.pd = 1'b1; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= FLAGS_PWR_ON;
            en_bits <= 2'b00;
        end else begin
            flags   <= f_nxt;
            en_bits <= e_nxt;
        end
    end

    assert_pwr_on_R1: assert property (@(posedge clk) disable iff (rst)
        kind == K_POR |=> !flags.por && flags.to && flags.pd && en_bits == 2'b00);

    assert_brown_R2: assert property (@(posedge clk) disable iff (rst)
        kind == K_BOR |=> !flags.bor && flags.to && flags.pd && en_bits == 2'b00
                          && flags.por == $past(flags.por));

    assert_wdt_rst_R4: assert property (@(posedge clk) disable iff (rst)
        kind == K_WDT_RST |=> !flags.to && flags.pd == $past(flags.pd)
                              && flags.por == $past(flags.por) && flags.bor == $past(flags.bor));

    assert_wdt_wake_R5: assert property (@(posedge clk) disable iff (rst)
        kind == K_WDT_WAKE |=> !flags.to && !flags.pd
                               && flags.por == $past(flags.por) && flags.bor == $past(flags.bor));

    assert_pin_awake_R6: assert property (@(posedge clk) disable iff (rst)
        kind == K_PIN_RST |=> $stable(flags) && $stable(en_bits));

    assert_pin_sleep_R7: assert property (@(posedge clk) disable iff (rst)
        kind == K_PIN_SLEEP |=> flags.to && !flags.pd);

    assert_por_fall_R13: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.por) |-> $past(kind) == K_POR);

    assert_bor_fall_R13: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.bor) |-> ($past(kind) == K_POR || $past(kind) == K_BOR));

endmodule

// File: rtl/rcf_pack.sv
module rcf_pack
    import rcf_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  flags_t              flags,
    input  logic [1:0]          en_bits,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [STAT_W-1:0]   stat_o
);

    localparam int ENA_POS = CTRL_W - 1;
    localparam int ENB_POS = CTRL_W - 2;

    always_comb begin
        ctrl_o          = '0;
        ctrl_o[ENA_POS] = en_bits[1];
        ctrl_o[ENB_POS] = en_bits[0];
        ctrl_o[POR_POS] = flags.por;
        ctrl_o[BOR_POS] = flags.bor;
    end

    assign stat_o = {flags.to, flags.pd, flags.por, flags.bor};

endmodule

// File: rtl/reset_cause_flags.sv
module reset_cause_flags
    import rcf_pkg::*;
#(
    parameter int CTRL_W   = 8,
    parameter int BORCFG_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ev_pwr_on,
    input  logic                ev_brown,
    input  logic                ev_wdt_rst,
    input  logic                ev_wdt_wake,
    input  logic                ev_pin_rst,
    input  logic                ev_pin_sleep,
    input  logic                ev_sleep_op,
    input  logic                ev_wdt_clr,
    input  logic                asleep,
    input  logic [BORCFG_W-1:0] bor_cfg,
    input  logic                wr_en,
    input  logic [CTRL_W-1:0]   wr_data,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [STAT_W-1:0]   stat_o
);

    localparam int ENA_POS = CTRL_W - 1;
    localparam int ENB_POS = CTRL_W - 2;

    rst_kind_e  kind;
    instr_e     instr;
    flags_t     flags;
    logic [1:0] en_bits;

    rcf_arbiter #(.BORCFG_W(BORCFG_W)) u_arb (
        .ev_pwr_on    (ev_pwr_on),
        .ev_brown     (ev_brown),
        .ev_wdt_rst   (ev_wdt_rst),
        .ev_wdt_wake  (ev_wdt_wake),
        .ev_pin_rst   (ev_pin_rst),
        .ev_pin_sleep (ev_pin_sleep),
        .ev_sleep_op  (ev_sleep_op),
        .ev_wdt_clr   (ev_wdt_clr),
        .asleep       (asleep),
        .bor_cfg      (bor_cfg),
        .kind         (kind),
        .instr        (instr)
    );

    rcf_flag_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .instr      (instr),
        .wr_en      (wr_en),
        .wr_por     (wr_data[POR_POS]),
        .wr_bor     (wr_data[BOR_POS]),
        .wr_en_bits ({wr_data[ENA_POS], wr_data[ENB_POS]}),
        .flags      (flags),
        .en_bits    (en_bits)
    );

    rcf_pack #(.CTRL_W(CTRL_W)) u_pack (
        .flags   (flags),
        .en_bits (en_bits),
        .ctrl_o  (ctrl_o),
        .stat_o  (stat_o)
    );

    assert_brown_off_R3: assert property (@(posedge clk) disable iff (rst)
        (ev_brown && bor_cfg == '0 && !ev_pwr_on && !ev_wdt_rst && !ev_wdt_wake
         && !ev_pin_rst && !ev_pin_sleep && !ev_sleep_op && !ev_wdt_clr && !wr_en)
        |=> $stable(ctrl_o) && $stable(stat_o));

    assert_ctrl_zero_R11: assert property (@(posedge clk) disable iff (rst)
        ctrl_o[ENB_POS-1:POR_POS+1] == '0);

    assert_prio_R10: assert property (@(posedge clk) disable iff (rst)
        ev_pwr_on |=> ctrl_o[POR_POS] == 1'b0 && stat_o[3:2] == 2'b11);

endmodule

// File: tb/sim_reset_cause_flags.sv
module sim_reset_cause_flags;

    logic       clk = 1'b0;
    logic       rst;
    logic       ev_pwr_on, ev_brown, ev_wdt_rst, ev_wdt_wake;
    logic       ev_pin_rst, ev_pin_sleep, ev_sleep_op, ev_wdt_clr;
    logic       asleep;
    logic [1:0] bor_cfg;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] ctrl_o;
    logic [3:0] stat_o;

    always #2.5 clk = ~clk;

    reset_cause_flags u0 (
        .clk(clk), .rst(rst),
        .ev_pwr_on(ev_pwr_on), .ev_brown(ev_brown),
        .ev_wdt_rst(ev_wdt_rst), .ev_wdt_wake(ev_wdt_wake),
        .ev_pin_rst(ev_pin_rst), .ev_pin_sleep(ev_pin_sleep),
        .ev_sleep_op(ev_sleep_op), .ev_wdt_clr(ev_wdt_clr),
        .asleep(asleep), .bor_cfg(bor_cfg),
        .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_o(ctrl_o), .stat_o(stat_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    logic m_por, m_bor, m_to, m_pd, m_ea, m_eb;
    bit   m_bk;   // brown-out flag known
    string m_tag;

    task automatic model_pwr_on();
        m_por = 0; m_bor = 0; m_bk = 0; m_to = 1; m_pd = 1; m_ea = 0; m_eb = 0;
    endtask

    task automatic model_step();
        int nev;
        nev = ev_pwr_on + (ev_brown && bor_cfg != 0) + ev_wdt_rst + ev_wdt_wake
              + ev_pin_rst + ev_pin_sleep;
        if (ev_pwr_on) begin
            model_pwr_on(); m_tag = "R1";
        end else if (ev_brown && bor_cfg != 2'b00) begin
            m_bor = 0; m_bk = 1; m_to = 1; m_pd = 1; m_ea = 0; m_eb = 0; m_tag = "R2";
        end else if (ev_wdt_wake || (ev_wdt_rst && asleep)) begin
            m_to = 0; m_pd = 0; m_tag = "R5";
        end else if (ev_wdt_rst) begin
            m_to = 0; m_tag = "R4";
        end else if (ev_pin_sleep || (ev_pin_rst && asleep)) begin
            m_to = 1; m_pd = 0; m_tag = "R7";
        end else if (ev_pin_rst) begin
            m_tag = "R6";
        end else begin
            m_tag = ev_brown ? "R3" : "R12";
            if (wr_en) begin
                if (wr_data[1]) m_por = 1;
                if (wr_data[0]) begin m_bor = 1; m_bk = 1; end
                m_ea = wr_data[7]; m_eb = wr_data[6];
                m_tag = "R9";
            end
            if (ev_sleep_op) begin m_to = 1; m_pd = 0; m_tag = "R8"; end
            else if (ev_wdt_clr) begin m_to = 1; m_pd = 1; m_tag = "R8"; end
        end
        if (nev > 1 || (nev == 1 && (wr_en || ev_sleep_op || ev_wdt_clr)))
            m_tag = "R10";
    endtask

    task automatic check(string tag);
        logic [7:0] exp_c, got_c;
        logic [3:0] exp_s, got_s;
        exp_c = {m_ea, m_eb, 4'b0000, m_por, m_bor};
        exp_s = {m_to, m_pd, m_por, m_bor};
        got_c = ctrl_o;
        got_s = stat_o;
        if (!m_bk) begin
            exp_c[0] = 0; got_c[0] = 0; exp_s[0] = 0; got_s[0] = 0;
        end
        n_chk++;
        if (got_c !== exp_c || got_s !== exp_s) begin
            n_bad++;
            $display("FAIL %s (R11 layout): ctrl=%b stat=%b expected ctrl=%b stat=%b",
                     tag, got_c, got_s, exp_c, exp_s);
        end
    endtask

    task automatic idle();
        ev_pwr_on = 0; ev_brown = 0; ev_wdt_rst = 0; ev_wdt_wake = 0;
        ev_pin_rst = 0; ev_pin_sleep = 0; ev_sleep_op = 0; ev_wdt_clr = 0;
        wr_en = 0; wr_data = 8'h00;
    endtask

    // inputs already driven; advance one edge, update model, compare after edge (R12)
    task automatic step(string tag_override);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag_override.len() != 0 ? tag_override : m_tag);
        idle();
    endtask

    task automatic write(logic [7:0] d);
        wr_en = 1; wr_data = d; step("R9");
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        idle();
        asleep = 0; bor_cfg = 2'b11; rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_pwr_on();
        check("R1");                     // reset state

        // R9: set flags, load enables, bits 5..2 ignored
        write(8'hFF);
        write(8'h00);                    // zeros do not clear flags (R13)
        write(8'h81);

        // R3: brown-out with detector off
        bor_cfg = 2'b00; ev_brown = 1; step("R3");
        bor_cfg = 2'b01; ev_brown = 1; step("R2");
        write(8'h43);

        // R4, R5, R6, R7
        ev_wdt_rst = 1; step("R4");
        ev_wdt_clr = 1; step("R8");
        asleep = 1; ev_wdt_rst = 1; step("R5");
        asleep = 0; ev_wdt_wake = 1; step("R5");
        ev_wdt_clr = 1; step("R8");
        ev_pin_rst = 1; step("R6");
        asleep = 1; ev_pin_rst = 1; step("R7");
        asleep = 0; ev_pin_sleep = 1; step("R7");
        ev_sleep_op = 1; ev_wdt_clr = 1; step("R8");

        // R10: priority combinations
        write(8'hC3);
        ev_brown = 1; ev_wdt_rst = 1; wr_en = 1; wr_data = 8'h00; step("R10");
        write(8'hC3);
        ev_pin_rst = 1; wr_en = 1; wr_data = 8'h00; ev_wdt_clr = 1; step("R10");
        ev_pwr_on = 1; ev_brown = 1; ev_pin_sleep = 1; step("R10");

        // random stimulus
        for (int i = 0; i < 3000; i++) begin
            ev_pwr_on    = ($urandom % 40) == 0;
            ev_brown     = ($urandom % 10) == 0;
            ev_wdt_rst   = ($urandom % 10) == 0;
            ev_wdt_wake  = ($urandom % 12) == 0;
            ev_pin_rst   = ($urandom % 10) == 0;
            ev_pin_sleep = ($urandom % 12) == 0;
            ev_sleep_op  = ($urandom % 6) == 0;
            ev_wdt_clr   = ($urandom % 6) == 0;
            asleep       = $urandom % 2;
            bor_cfg      = $urandom % 4;
            wr_en        = ($urandom % 4) == 0;
            wr_data      = $urandom % 256;
            step("");
        end

        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule